// File: doc/BRIEF.md
# Circular-Buffer Data Address Generator

This block supplies addresses to a signal-processing data or coefficient memory. It keeps four pointer registers, four step registers and four span registers. Each pointer is paired with the span register of the same number. On an indirect access the selected pointer goes straight out as the memory address in the same cycle. At the next clock edge that pointer advances by whichever step register the access names. The pointer number and the step number are chosen independently of each other.

When the paired span is nonzero, the pointer stays inside a circular buffer of that many words. The buffer starts at the pointer value rounded down to a multiple of the smallest power of two that is not below the span. After a step, a pointer that lands at or past the buffer end is pulled back by one span. A pointer that lands below the buffer start is pushed forward by one span. This keeps forward and backward steps of any size smaller than the span correct, with no extra cycle.

An optional per-access flag drives the address out with its bit order reversed, which gives the reordering an FFT needs. All twelve registers are loaded and read through a small register port.

Top module: `circ_addr_gen`

## Requirements
- R1: After reset every pointer, step and span register reads back as zero.
- R2: While `acc_en` is high, `addr_out` equals the pointer selected by `acc_i` in that same cycle, and `addr_vld` follows `acc_en`.
- R3: An access with `acc_en` high changes only the selected pointer, at the next rising edge. The new value is the old pointer plus the step register selected by `acc_m`, and any step register may be paired with any pointer. Without an access or a write, the pointers hold their values.
- R4: With the paired span equal to zero, the post-modify is plain addition modulo 2^14. For example, 0x3FFF plus 1 gives 0.
- R5: With a nonzero span L, let P be the smallest power of two that is at least L, and let the base be the pointer rounded down to a multiple of P. A stepped pointer that reaches or passes base+L has L subtracted.
- R6: With a nonzero span, a stepped pointer that falls below the base has L added. Step values are 14-bit two's complement, so a negative step walks backwards through the buffer.
- R7: With `acc_brev` high, `addr_out` carries the pointer with bit 0 and bit 13 exchanged, bit 1 and bit 12 exchanged, and so on. The stored pointer is never reversed.
- R8: Register port encoding for `reg_sel`: 0 selects a pointer, 1 a step, 2 a span. `reg_idx` chooses one of the four registers. A write with `reg_we` takes effect at the next edge, and `reg_rdata` shows the selected register combinationally. The value 3 reads as zero, and writes to it change nothing.
- R9: When a register write and an access target the same pointer in one cycle, the written value is what the pointer holds afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Perform an indirect access this cycle |
| acc_i | input | 2 | Pointer register used for the access |
| acc_m | input | 2 | Step register applied after the access |
| acc_brev | input | 1 | Drive the address bit-reversed |
| addr_out | output | 14 | Memory address |
| addr_vld | output | 1 | Address is valid |
| reg_we | input | 1 | Register port write strobe |
| reg_sel | input | 2 | Register kind: 0 pointer, 1 step, 2 span |
| reg_idx | input | 2 | Register number within the kind |
| reg_wdata | input | 14 | Register write data |
| reg_rdata | output | 14 | Selected register contents |

## Verification
The pointers are driven through several step patterns. A small positive linear step shows plain addition. A step across the top of the 14-bit space shows the linear wrap. A step of 3 through a 10-word buffer whose span is not a power of two shows whether the end test uses "reaches or passes" rather than equality. A step of -4 through a 7-word buffer shows whether the underflow correction is present. Pairing one pointer with step registers of different numbers tells independent selection apart from fixed pairing. Bit-reversed accesses followed by a read-back of the pointer show whether the reversal stays on the output only. A write that collides with an access, and accesses to the unused register kind, settle the priority and the decode.

// File: rtl/circ_addr_gen.sv
module circ_addr_gen #(
  parameter int AW   = 14,
  parameter int NREG = 4,
  parameter int IW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_en,
  input  logic [IW-1:0] acc_i,
  input  logic [IW-1:0] acc_m,
  input  logic          acc_brev,
  output logic [AW-1:0] addr_out,
  output logic          addr_vld,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [IW-1:0] reg_idx,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata
);
  localparam int SW = AW + 2;

  logic [NREG-1:0][AW-1:0] idx_q, mod_q, len_q;

  function automatic logic [AW-1:0] smear(input logic [AW-1:0] v);
    logic [AW-1:0] r;
    r = v;
    for (int k = 1; k < AW; k++) r = r | (v >> k);
    return r;
  endfunction

  wire [AW-1:0] cur  = idx_q[acc_i];
  wire [AW-1:0] modv = mod_q[acc_m];
  wire [AW-1:0] lenv = len_q[acc_i];
  wire [AW-1:0] msk  = smear(lenv - 1'b1);
  wire [AW-1:0] base = cur & ~msk;

  wire signed [SW-1:0] sum   = $signed({2'b00, cur}) + $signed({{2{modv[AW-1]}}, modv});
  wire signed [SW-1:0] lo    = $signed({2'b00, base});
  wire signed [SW-1:0] span  = $signed({2'b00, lenv});
  wire signed [SW-1:0] hi    = lo + span;
  wire signed [SW-1:0] wrapd = (sum >= hi) ? sum - span : (sum < lo) ? sum + span : sum;
  wire [AW-1:0] nxt = (lenv == '0) ? sum[AW-1:0] : wrapd[AW-1:0];

  logic [AW-1:0] rev;
  always_comb
    for (int b = 0; b < AW; b++) rev[b] = cur[AW-1-b];

  assign addr_out = acc_brev ? rev : cur;
  assign addr_vld = acc_en;

  always_comb
    case (reg_sel)
      2'd0:    reg_rdata = idx_q[reg_idx];
      2'd1:    reg_rdata = mod_q[reg_idx];
      2'd2:    reg_rdata = len_q[reg_idx];
      default: reg_rdata = '0;
    endcase

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      mod_q <= '0;
      len_q <= '0;
    end else begin
      if (acc_en) idx_q[acc_i] <= nxt;
      if (reg_we)
        case (reg_sel)
          2'd0:    idx_q[reg_idx] <= reg_wdata;
          2'd1:    mod_q[reg_idx] <= reg_wdata;
          2'd2:    len_q[reg_idx] <= reg_wdata;
          default: ;
        endcase
    end
  end
endmodule

// File: rtl/circ_addr_gen_chk.sv
module circ_addr_gen_chk #(
  parameter int AW   = 14,
  parameter int NREG = 4,
  parameter int IW   = $clog2(NREG)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    acc_en,
  input logic [IW-1:0]           acc_i,
  input logic [IW-1:0]           acc_m,
  input logic                    acc_brev,
  input logic [AW-1:0]           addr_out,
  input logic                    reg_we,
  input logic [1:0]              reg_sel,
  input logic [IW-1:0]           reg_idx,
  input logic [AW-1:0]           reg_wdata,
  input logic [NREG-1:0][AW-1:0] idx_q,
  input logic [NREG-1:0][AW-1:0] mod_q,
  input logic [NREG-1:0][AW-1:0] len_q
);
  function automatic int pow2_at_least(input int n);
    int p;
    p = 1;
    while (p < n) p = p * 2;
    return p;
  endfunction

  function automatic logic [AW-1:0] flip(input logic [AW-1:0] v);
    logic [AW-1:0] r;
    for (int b = 0; b < AW; b++) r[b] = v[AW-1-b];
    return r;
  endfunction

  int ptr_c, len_c, stp_c, pw_c;
  logic circ_ok;
  always_comb begin
    ptr_c = int'(idx_q[acc_i]);
    len_c = int'(len_q[acc_i]);
    stp_c = mod_q[acc_m][AW-1] ? (1 << AW) - int'(mod_q[acc_m]) : int'(mod_q[acc_m]);
    pw_c  = pow2_at_least(len_c);
    circ_ok = acc_en && !reg_we && len_c != 0 && stp_c < len_c && (ptr_c % pw_c) < len_c;
  end

  // R2
  addr_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en && !acc_brev |-> addr_out == idx_q[acc_i]);

  // R7
  brev_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en && acc_brev |-> flip(addr_out) == idx_q[acc_i]);

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en && !reg_we |=> $stable(idx_q));

  // R5
  in_buffer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    circ_ok |=> (int'(idx_q[$past(acc_i)]) % $past(pw_c)) < $past(len_c) &&
                (int'(idx_q[$past(acc_i)]) / $past(pw_c)) == ($past(ptr_c) / $past(pw_c)));

  // R8
  write_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_sel == 2'd0 |=> idx_q[$past(reg_idx)] == $past(reg_wdata));
endmodule

bind circ_addr_gen circ_addr_gen_chk #(.AW(AW), .NREG(NREG), .IW(IW)) u_chk (.*);

// File: tb/test_circ_addr_gen.sv
module test_circ_addr_gen;
  logic clk = 0, rst_n = 0;
  logic acc_en = 0, acc_brev = 0, reg_we = 0;
  logic [1:0] acc_i = 0, acc_m = 0, reg_sel = 0, reg_idx = 0;
  logic [13:0] reg_wdata = 0;
  logic [13:0] addr_out, reg_rdata;
  logic addr_vld;
  int errors = 0, checks = 0;
  bit done = 0;
  int rm [3][4];

  always #5 clk = ~clk;

  circ_addr_gen i_circ_addr_gen (.*);

  function automatic int model_rev(input int v);
    int r = 0;
    for (int b = 0; b < 14; b++) if (v & (1 << b)) r |= 1 << (13 - b);
    return r;
  endfunction

  function automatic int model_next(input int p, input int st, input int l);
    int s, n, pw, bs;
    s = (st >= 8192) ? st - 16384 : st;
    n = p + s;
    if (l != 0) begin
      pw = 1;
      while (pw < l) pw *= 2;
      bs = p - (p % pw);
      if (n >= bs + l) n -= l;
      else if (n < bs) n += l;
    end
    return n & 16383;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input bit en, input int i, input int m, input bit br,
                      input bit we, input int sel, input int ri, input int wd);
    int exp_rd, nx;
    @(negedge clk);
    acc_en = en; acc_i = 2'(i); acc_m = 2'(m); acc_brev = br;
    reg_we = we; reg_sel = 2'(sel); reg_idx = 2'(ri); reg_wdata = 14'(wd);
    #1;
    exp_rd = (sel < 3) ? rm[sel][ri] : 0;
    check({tag, " rdata"}, int'(reg_rdata), exp_rd);
    check({tag, " vld"}, int'(addr_vld), int'(en));
    if (en) check({tag, " addr"}, int'(addr_out), br ? model_rev(rm[0][i]) : rm[0][i]);
    nx = model_next(rm[0][i], rm[1][m], rm[2][i]);
    @(posedge clk);
    if (en) rm[0][i] = nx;
    if (we && sel < 3) rm[sel][ri] = wd;
  endtask

  task automatic wr(input string tag, input int sel, input int ri, input int wd);
    step(tag, 0, 0, 0, 0, 1, sel, ri, wd);
  endtask

  task automatic acc(input string tag, input int i, input int m, input bit br);
    step(tag, 1, i, m, br, 0, 0, i, 0);
  endtask

  initial begin
    foreach (rm[a, b]) rm[a][b] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int s = 0; s < 3; s++)
      for (int r = 0; r < 4; r++) step("R1 reset read", 0, 0, 0, 0, 0, s, r, 0);

    wr("R8 wr", 0, 0, 100); wr("R8 wr", 1, 3, 5); wr("R8 wr", 1, 0, 1);
    for (int k = 0; k < 4; k++) acc("R3 R4 linear", 0, 3, 0);
    step("R3 idle", 0, 0, 0, 0, 0, 0, 0, 0);
    acc("R3 pair m0", 0, 0, 0);

    wr("R8 wr", 0, 1, 16'h3FFE);
    for (int k = 0; k < 3; k++) acc("R4 top wrap", 1, 0, 0);

    wr("R8 wr", 0, 2, 16); wr("R8 wr", 2, 2, 10); wr("R8 wr", 1, 1, 3);
    for (int k = 0; k < 12; k++) acc("R5 fwd wrap", 2, 1, 0);

    wr("R8 wr", 0, 3, 40); wr("R8 wr", 2, 3, 7); wr("R8 wr", 1, 2, 16'h3FFC);
    for (int k = 0; k < 10; k++) acc("R6 back wrap", 3, 2, 0);
    for (int k = 0; k < 6; k++) acc("R3 R6 cross pair", 2, 2, 0);
    for (int k = 0; k < 3; k++) acc("R5 cross pair", 3, 1, 0);

    wr("R7 wr", 0, 0, 16'h0005);
    for (int k = 0; k < 4; k++) acc("R7 brev", 0, 0, 1);
    step("R7 readback", 0, 0, 0, 0, 0, 0, 0, 0);

    step("R8 sel3 wr", 0, 0, 0, 0, 1, 3, 1, 16'h1234);
    for (int r = 0; r < 4; r++) step("R8 sel3 read", 0, 0, 0, 0, 0, 3, r, 0);
    for (int s = 0; s < 3; s++) step("R8 readback", 0, 0, 0, 0, 0, s, 1, 0);

    step("R9 collide", 1, 2, 1, 0, 1, 0, 2, 200);
    step("R9 after", 1, 2, 1, 0, 0, 0, 2, 0);
    step("R9 after", 0, 0, 0, 0, 0, 0, 2, 0);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule